// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word addresses of a four-beat burst inside a synchronous memory. A burst-start strobe captures a full external address. The first beat of the burst is that address, used exactly as supplied. The block then generates the next three beats internally by changing only the two low-order bits. The upper bits stay as captured for the whole burst, and after the fourth beat the low bits wrap back to the start offset.

An active-low advance input steps the burst on a rising clock edge. When advance is high, the current address is held, which suspends the burst. An order input selects one of two sequences. With the input low, the low bits count up modulo 4 from the start offset. With it high, each beat is the start offset XORed with a beat count. The order is sampled only when a burst starts, so a change in the middle of a burst has no effect until the next start. Outputs come straight from registers, so each result is visible one clock edge after the input that causes it.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_o and beat_o are all zeros.
- R2: On a clock edge where start_i is high, addr_o takes the value of addr_i. This holds whatever the value of adv_n_i.
- R3: With order_i low at the start, the low two bits advance as (start + n) modulo 4. For example, a start at 2 gives 2, 3, 0, 1.
- R4: With order_i high at the start, the low two bits are start XOR n. A start at 1 gives 1, 0, 3, 2. A start at 2 gives 2, 3, 0, 1. A start at 3 gives 3, 2, 1, 0.
- R5: After four advances, the low two bits return to the start offset. No carry reaches the upper bits.
- R6: On an edge where start_i is low and adv_n_i is high, addr_o keeps its value.
- R7: The address bits above the low two change only on an edge where start_i is high.
- R8: A change of order_i while a burst runs does not change the sequence until the next start.
- R9: beat_o always equals the low two bits of addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst-start strobe; captures addr_i |
| adv_n_i | input | 1 | Advance, active low; high suspends |
| order_i | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_i | input | 16 | External start address |
| addr_o | output | 16 | Current burst address |
| beat_o | output | 2 | Current low two address bits |

## Verification
Every result is due one rising edge after the inputs that cause it: a load, an advance or a hold each shows on addr_o after exactly one register stage. The bench drives inputs just after a falling edge and updates its reference model as of the next rising edge. It then compares both outputs at the following falling edge, so each check lands half a cycle after the edge that produced the value. Mode changes in the middle of a burst and four-advance wraps are compared in the same way on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;
endpackage

// File: rtl/burst_seq_track.sv
module burst_seq_track
   import burst_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter int BW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          step_n_i,
   input  logic          ord_i,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] base_o,
   output logic [BW-1:0] cnt_o,
   output order_e        ord_o
);
   logic [AW-1:0] base_q;
   logic [BW-1:0] cnt_q;
   order_e        ord_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         ord_q  <= ORD_LINEAR;
      end else if (load_i) begin
         base_q <= addr_i;
         cnt_q  <= '0;
         ord_q  <= order_e'(ord_i);
      end else if (!step_n_i) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign base_o = base_q;
   assign cnt_o  = cnt_q;
   assign ord_o  = ord_q;

   // R8: the captured order changes only on a load
   a_r8_order_held : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(ord_q));
   // R5: the beat count steps by one per advance and wraps
   a_r5_count_step : assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_n_i) |=> (cnt_q == BW'($past(cnt_q) + 1'b1)));
   // R2: the count restarts on every load
   a_r2_count_clear : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == '0));
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
   import burst_seq_pkg::*;
#(
   parameter int BW = 2
) (
   input  logic [BW-1:0] start_i,
   input  logic [BW-1:0] cnt_i,
   input  order_e        ord_i,
   output logic [BW-1:0] off_o
);
   logic [BW-1:0] lin_off;
   logic [BW-1:0] ilv_off;
   logic [BW:0]   carry;

   assign carry[0] = 1'b0;
   genvar b;
   generate
      for (b = 0; b < BW; b++) begin : g_bit
         assign ilv_off[b]  = start_i[b] ^ cnt_i[b];
         assign lin_off[b]  = start_i[b] ^ cnt_i[b] ^ carry[b];
         assign carry[b+1]  = (start_i[b] & cnt_i[b]) |
                              (carry[b] & (start_i[b] ^ cnt_i[b]));
      end
   endgenerate

   assign off_o = (ord_i == ORD_INTERLEAVE) ? ilv_off : lin_off;

   // R3 / R4: a zero count leaves the start offset untouched in either order
   always_comb begin
      if (cnt_i == '0) a_r5_zero_count : assert (off_o == start_i);
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              adv_n_i,
   input  logic              order_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BEAT_W-1:0] beat_o
);
   localparam int HI_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1 || BEAT_W >= ADDR_W) begin : g_bad_width
         $error("burst_addr_seq: BEAT_W must be at least 1 and below ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [BEAT_W-1:0] cnt;
   logic [BEAT_W-1:0] off;
   order_e            ord;

   burst_seq_track #(.AW(ADDR_W), .BW(BEAT_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .step_n_i (adv_n_i),
      .ord_i    (order_i),
      .addr_i   (addr_i),
      .base_o   (base),
      .cnt_o    (cnt),
      .ord_o    (ord)
   );

   burst_seq_order #(.BW(BEAT_W)) u_order (
      .start_i (base[BEAT_W-1:0]),
      .cnt_i   (cnt),
      .ord_i   (ord),
      .off_o   (off)
   );

   assign addr_o = {base[ADDR_W-1:BEAT_W], off};
   assign beat_o = off;

   // R2: a start strobe presents the external address on the next edge
   a_r2_load : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (addr_o == $past(addr_i)));
   // R6: suspended burst holds the address
   a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && adv_n_i) |=> $stable(addr_o));
   // R7: upper bits fixed between loads
   a_r7_upper : assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
   // R9: beat output mirrors the low address bits
   a_r9_beat : assert property (@(posedge clk) disable iff (!rst_n)
      beat_o == addr_o[BEAT_W-1:0]);
   // R6: an advance always moves the offset
   a_r6_moves : assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !adv_n_i) |=> (beat_o != $past(beat_o)));
   initial begin
      if (HI_W < 1) $display("burst_addr_seq: no upper bits");
   end
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        adv_n_i = 1'b1;
   logic        order_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic [15:0] addr_o;
   logic [1:0]  beat_o;

   int checks = 0;
   int fails  = 0;

   // reference state
   logic [15:0] m_base = '0;
   int          m_cnt  = 0;
   logic        m_ord  = 1'b0;

   always #4 clk = ~clk;

   burst_addr_seq i_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_n_i(adv_n_i),
      .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
   );

   function automatic logic [15:0] expect_addr();
      int s;
      int o;
      s = int'(m_base[1:0]);
      o = m_ord ? (s ^ m_cnt) : ((s + m_cnt) % 4);
      return {m_base[15:2], 2'(o)};
   endfunction

   task automatic check(input string tag, input logic [15:0] exp);
      checks++;
      if (addr_o !== exp || beat_o !== exp[1:0]) begin
         fails++;
         $display("FAIL %s: addr_o=%h beat_o=%0d expected addr=%h beat=%0d",
                  tag, addr_o, beat_o, exp, exp[1:0]);
      end
   endtask

   // drive one cycle, advance the model, sample at the next falling edge
   task automatic cyc(input logic ld, input logic advn, input logic md,
                      input logic [15:0] a, input string tag);
      start_i = ld; adv_n_i = advn; order_i = md; addr_i = a;
      if (ld) begin
         m_base = a; m_cnt = 0; m_ord = md;
      end else if (!advn) begin
         m_cnt = (m_cnt + 1) % 4;
      end
      @(negedge clk);
      check(tag, expect_addr());
   endtask

   task automatic lit(input string tag, input logic [1:0] v);
      checks++;
      if (beat_o !== v) begin
         fails++;
         $display("FAIL %s: beat_o=%0d expected %0d", tag, beat_o, v);
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1 reset", 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 16'h0000);

      // R3 linear from 2: 2,3,0,1 then wrap (R5)
      cyc(1, 1, 0, 16'hA5F2, "R2 load linear");
      lit("R3 beat0", 2'd2);
      cyc(0, 0, 0, 0, "R3 linear");  lit("R3 beat1", 2'd3);
      cyc(0, 0, 0, 0, "R3 linear");  lit("R3 beat2", 2'd0);
      cyc(0, 0, 0, 0, "R3 linear");  lit("R3 beat3", 2'd1);
      cyc(0, 0, 0, 0, "R5 wrap linear"); lit("R5 wrap", 2'd2);

      // R4 interleaved starts 1, 2, 3 with literal sequences
      for (int s = 1; s < 4; s++) begin
         cyc(1, 0, 1, 16'h3C00 | 16'(s), "R2 load with advance low");
         for (int k = 0; k < 4; k++) begin
            lit("R4 interleave", 2'(s ^ k));
            cyc(0, 0, 1, 0, "R4 interleave");
         end
         lit("R5 wrap interleave", 2'(s));
      end

      // R6 hold, R8 mode change mid-burst
      cyc(1, 1, 0, 16'h1233, "R2 load");
      cyc(0, 0, 1, 0, "R8 order flip ignored");
      lit("R8 linear kept", 2'd0);
      cyc(0, 1, 1, 0, "R6 hold");
      cyc(0, 1, 0, 16'hFFFF, "R6 hold addr_i ignored");
      cyc(0, 0, 1, 0, "R8 linear kept");
      lit("R8 beat", 2'd1);
      cyc(0, 0, 0, 0, "R7 no carry");
      lit("R7 low", 2'd2);
      check("R7 upper", 16'h1232);

      // mixed pattern, every cycle compared (R9 via beat_o)
      for (int i = 0; i < 200; i++) begin
         logic ld;
         ld = ((i * 7) % 11) == 0;
         cyc(ld, logic'(((i * 5) % 3) == 0), logic'((i / 13) % 2),
             16'(i * 16'h9E37), "R9 mixed");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule